// File: doc/BRIEF.md
# Return-Address Stack Unit

This block keeps the saved return addresses of a small processor with a 16-bit program counter. Subroutine calls and hardware interrupts share one stack. The stack holds eight entries by default. A call stores the current PC and steers the processor to the target address. A return steers it back to the most recently stored address.

An interrupt request works like a call that the hardware starts. Four request lines feed the block, and the lowest-numbered line that is asserted wins. The accepted source selects its own handler address, `VEC_BASE + index * VEC_STRIDE`. Accepting an interrupt sets a global mask, and an interrupt-return clears it.

All pins are plain control and status pins. No data stream passes through this block, so it has no valid/ready handshake and never applies back-pressure. `next_pc_o` is combinational from the current inputs and the stored state. The stack, the mask and the two flags change on the rising clock edge. The flags are registered one-cycle pulses that report the operation of the edge just taken.

Top module: `retstack_unit`

## Requirements
- R1: With `call_i` high and a free entry, `next_pc_o` equals `target_i` in the same cycle, and `pc_i` is stored as the newest entry at the clock edge.
- R2: With `ret_i` high and a stored entry, `next_pc_o` equals the newest stored entry in the same cycle, and that entry is removed at the edge. Entries come back last-in, first-out.
- R3: The stack holds DEPTH (8) entries. A call while full leaves the stack unchanged and makes `next_pc_o` equal `pc_i`. An accepted interrupt request while full does the same and also leaves the mask unchanged. In both cases `overflow_o` is high for exactly the one cycle after that edge.
- R4: A return or interrupt-return while empty makes `next_pc_o` equal `pc_i` and leaves the stack empty. `underflow_o` is high for exactly the one cycle after that edge.
- R5: An accepted request on line k makes `next_pc_o` equal `VEC_BASE + k*VEC_STRIDE` (0x0100, 0x0104, 0x0108, 0x010C by default). It stores `pc_i` and sets the mask.
- R6: When several request lines are high, the lowest index is served.
- R7: While the mask is set, requests are ignored: `next_pc_o` equals `pc_i` and nothing is stored.
- R8: A request in the same cycle as a call, return or interrupt-return is ignored, and the other operation proceeds.
- R9: `iret_i` pops like a return and clears the mask at the same edge.
- R10: Reset empties the stack, clears the mask and clears both flags. With no operation active, `next_pc_o` equals `pc_i`.
- R11: When `call_i` and `ret_i` are both high, the call is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Subroutine call this cycle |
| ret_i | input | 1 | Subroutine return this cycle |
| iret_i | input | 1 | Return from interrupt handler this cycle |
| irq_i | input | N_SRC | Interrupt request lines, index 0 highest priority |
| pc_i | input | PC_W | Current program counter |
| target_i | input | PC_W | Call destination address |
| next_pc_o | output | PC_W | Program counter the processor should load |
| overflow_o | output | 1 | Pulse: a push was refused because the stack was full |
| underflow_o | output | 1 | Pulse: a pop was refused because the stack was empty |

## Verification
A corrupted stack entry stays hidden until the return that reaches it. At that cycle `next_pc_o` shows a wrong address, which can be many operations after the corruption. A stack pointer that is off by one shows two ways. Returns come back in the wrong order, or the overflow or underflow flag pulses one operation early or late, so every stack test drains the stack to underflow. A mask that is stuck set or stuck clear shows on the very next request: the handler address appears where `pc_i` was expected, or the reverse.

// File: rtl/retstack_pkg.sv
package retstack_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_CALL = 3'd1,
    OP_RET  = 3'd2,
    OP_IRET = 3'd3,
    OP_IRQ  = 3'd4
  } rs_op_e;
endpackage

// File: rtl/retstack_arbiter.sv
module retstack_arbiter
  import retstack_pkg::*;
#(
  parameter int N_SRC = 4,
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             iret_i,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             mask_i,
  output rs_op_e           op_o,
  output logic [SW-1:0]    src_o
);
  logic [N_SRC-1:0] grant;
  logic             any_req;

  // Priority select: scan downward so the lowest set index is the last one written.
  always_comb begin
    grant = '0;
    src_o = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (irq_i[k]) begin
        grant = '0;
        grant[k] = 1'b1;
        src_o = SW'(k);
      end
    end
  end

  assign any_req = |irq_i;

  always_comb begin
    if (call_i)                  op_o = OP_CALL;
    else if (ret_i)              op_o = OP_RET;
    else if (iret_i)             op_o = OP_IRET;
    else if (any_req && !mask_i) op_o = OP_IRQ;
    else                         op_o = OP_IDLE;
  end

  // R6
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  // R7
  masked_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |-> op_o != OP_IRQ);

  // R8
  req_yield_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i || ret_i || iret_i) |-> op_o != OP_IRQ);
endmodule

// File: rtl/retstack_vector.sv
module retstack_vector #(
  parameter int               N_SRC      = 4,
  parameter int               PC_W       = 16,
  parameter logic [PC_W-1:0]  VEC_BASE   = 16'h0100,
  parameter int               VEC_STRIDE = 4,
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [SW-1:0]   src_i,
  output logic [PC_W-1:0] handler_o
);
  logic [PC_W-1:0] table_q [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_vec
    assign table_q[g] = VEC_BASE + PC_W'(g * VEC_STRIDE);
  end

  always_comb begin
    handler_o = table_q[0];
    for (int k = 0; k < N_SRC; k++)
      if (src_i == SW'(k)) handler_o = table_q[k];
  end
endmodule

// File: rtl/retstack_store.sv
module retstack_store #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] din_i,
  output logic [PC_W-1:0] top_o,
  output logic            full_o,
  output logic            empty_o,
  output logic            ovf_o,
  output logic            udf_o
);
  logic [PC_W-1:0] mem_q [DEPTH];
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   cnt_dec;
  logic            do_push;
  logic            do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign cnt_dec = cnt_q - 1'b1;
  assign top_o   = empty_o ? '0 : mem_q[cnt_dec[IW-1:0]];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      ovf_o <= push_i && full_o;
      udf_o <= pop_i && empty_o;
      if (do_push)     cnt_q <= cnt_q + 1'b1;
      else if (do_pop) cnt_q <= cnt_dec;
    end
  end

  // Entries carry no reset; the counter guards every read.
  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[cnt_q[IW-1:0]] <= din_i;
  end

  // R3
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R1
  push_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R2
  pop_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R3
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> ovf_o && $stable(cnt_q));

  // R4
  empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> udf_o && cnt_q == '0);
endmodule

// File: rtl/retstack_unit.sv
module retstack_unit
  import retstack_pkg::*;
#(
  parameter int              PC_W       = 16,
  parameter int              DEPTH      = 8,
  parameter int              N_SRC      = 4,
  parameter logic [PC_W-1:0] VEC_BASE   = 16'h0100,
  parameter int              VEC_STRIDE = 4,
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             iret_i,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  target_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  rs_op_e          op;
  logic [SW-1:0]   src;
  logic [PC_W-1:0] handler;
  logic [PC_W-1:0] top;
  logic            full, empty, push, pop, mask_q;

  retstack_arbiter #(.N_SRC(N_SRC)) arb_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .call_i(call_i), .ret_i(ret_i),
    .iret_i(iret_i), .irq_i(irq_i), .mask_i(mask_q), .op_o(op), .src_o(src)
  );

  retstack_vector #(
    .N_SRC(N_SRC), .PC_W(PC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) vec_i (
    .src_i(src), .handler_o(handler)
  );

  assign push = (op == OP_CALL) || (op == OP_IRQ);
  assign pop  = (op == OP_RET)  || (op == OP_IRET);

  retstack_store #(.DEPTH(DEPTH), .PC_W(PC_W)) store_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pop_i(pop), .din_i(pc_i),
    .top_o(top), .full_o(full), .empty_o(empty),
    .ovf_o(overflow_o), .udf_o(underflow_o)
  );

  always_comb begin
    unique case (op)
      OP_CALL:         next_pc_o = full  ? pc_i : target_i;
      OP_RET, OP_IRET: next_pc_o = empty ? pc_i : top;
      OP_IRQ:          next_pc_o = full  ? pc_i : handler;
      default:         next_pc_o = pc_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   mask_q <= 1'b0;
    else if (op == OP_IRET)        mask_q <= 1'b0;
    else if (op == OP_IRQ && !full) mask_q <= 1'b1;
  end

  // R5
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_IRQ && !full) |=> mask_q);

  // R9
  iret_unmask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iret_i && !call_i && !ret_i |=> !mask_q);

  // R10
  idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!call_i && !ret_i && !iret_i && irq_i == '0) |-> next_pc_o == pc_i);
endmodule

// File: tb/retstack_unit_tb.sv
module retstack_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call, ret, iret;
  logic [3:0]  irq;
  logic [15:0] pc, tgt, npc;
  logic        ovf, udf;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  retstack_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .ret_i(ret), .iret_i(iret),
    .irq_i(irq), .pc_i(pc), .target_i(tgt), .next_pc_o(npc),
    .overflow_o(ovf), .underflow_o(udf)
  );

  // {call, ret, iret, irq[3:0], pc, target, expected next pc}
  localparam int NV = 14;
  localparam logic [54:0] VECS [NV] = '{
    {1'b1,1'b0,1'b0,4'b0000,16'h0010,16'h0200,16'h0200}, // R1 call
    {1'b1,1'b0,1'b0,4'b0000,16'h0205,16'h0300,16'h0300}, // R1 nested call
    {1'b0,1'b1,1'b0,4'b0000,16'h0310,16'h0000,16'h0205}, // R2 return
    {1'b0,1'b0,1'b0,4'b0110,16'h0206,16'h0000,16'h0104}, // R5 R6 line 1 wins
    {1'b0,1'b0,1'b0,4'b0001,16'h0104,16'h0000,16'h0104}, // R7 masked
    {1'b0,1'b0,1'b1,4'b0000,16'h0108,16'h0000,16'h0206}, // R9 iret
    {1'b0,1'b0,1'b0,4'b1000,16'h0207,16'h0000,16'h010C}, // R5 line 3
    {1'b0,1'b0,1'b1,4'b0000,16'h0110,16'h0000,16'h0207}, // R9 iret
    {1'b1,1'b0,1'b0,4'b0001,16'h0208,16'h0400,16'h0400}, // R8 req with call
    {1'b0,1'b1,1'b0,4'b0001,16'h0401,16'h0000,16'h0208}, // R8 req with return
    {1'b1,1'b1,1'b0,4'b0000,16'h0209,16'h0500,16'h0500}, // R11 call beats return
    {1'b0,1'b1,1'b0,4'b0000,16'h0501,16'h0000,16'h0209}, // R11 only one entry pushed
    {1'b0,1'b1,1'b0,4'b0000,16'h0020,16'h0000,16'h0010}, // R2 oldest entry
    {1'b0,1'b0,1'b0,4'b0000,16'h0011,16'h0000,16'h0011}  // R10 idle pass
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic r, input logic ir, input logic [3:0] q,
                      input logic [15:0] p, input logic [15:0] t, input logic [15:0] e,
                      input logic eo, input logic eu, input string req);
    @(negedge clk);
    call = c; ret = r; iret = ir; irq = q; pc = p; tgt = t;
    #1 chk(req, npc, e);
    @(posedge clk);
    #1;
    chk(req, {15'd0, ovf}, {15'd0, eo});
    chk(req, {15'd0, udf}, {15'd0, eu});
  endtask

  initial begin
    call = 0; ret = 0; iret = 0; irq = 0; pc = 16'h0042; tgt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R10 reset ovf", {15'd0, ovf}, 16'd0);
    chk("R10 reset udf", {15'd0, udf}, 16'd0);
    chk("R10 reset pass", npc, 16'h0042);

    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      v = VECS[i];
      step(v[54], v[53], v[52], v[51:48], v[47:32], v[31:16], v[15:0], 1'b0, 1'b0, "R1-table");
    end

    // R4: return on empty stack
    step(0, 1, 0, 4'b0000, 16'h0777, 16'h0, 16'h0777, 1'b0, 1'b1, "R4 underflow");
    step(0, 0, 0, 4'b0000, 16'h0778, 16'h0, 16'h0778, 1'b0, 1'b0, "R4 pulse ends");

    // R3: fill, overflow by call and by request, then drain in order
    for (int i = 0; i < 8; i++)
      step(1, 0, 0, 4'b0000, 16'h1000 + 16'(i), 16'h2000 + 16'(i), 16'h2000 + 16'(i),
           1'b0, 1'b0, "R3 fill");
    step(1, 0, 0, 4'b0000, 16'h1FFF, 16'h3333, 16'h1FFF, 1'b1, 1'b0, "R3 call overflow");
    step(0, 0, 0, 4'b0001, 16'h1EEE, 16'h0, 16'h1EEE, 1'b1, 1'b0, "R3 irq overflow");
    step(0, 0, 0, 4'b0000, 16'h1DDD, 16'h0, 16'h1DDD, 1'b0, 1'b0, "R3 pulse ends");
    for (int i = 7; i >= 0; i--)
      step(0, 1, 0, 4'b0000, 16'h5000, 16'h0, 16'h1000 + 16'(i), 1'b0, 1'b0, "R3 drain");
    step(0, 0, 1, 4'b0000, 16'h5001, 16'h0, 16'h5001, 1'b0, 1'b1, "R4 iret underflow");

    // R10: reset mid-run clears stack and mask
    step(1, 0, 0, 4'b0000, 16'h0600, 16'h0700, 16'h0700, 1'b0, 1'b0, "R10 pre call");
    step(0, 0, 0, 4'b0010, 16'h0701, 16'h0, 16'h0104, 1'b0, 1'b0, "R10 pre irq");
    @(negedge clk);
    call = 0; ret = 0; iret = 0; irq = 0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(0, 0, 0, 4'b0001, 16'h0800, 16'h0, 16'h0100, 1'b0, 1'b0, "R10 mask cleared");
    step(0, 0, 1, 4'b0000, 16'h0801, 16'h0, 16'h0800, 1'b0, 1'b0, "R10 fresh entry");
    step(0, 1, 0, 4'b0000, 16'h0802, 16'h0, 16'h0802, 1'b0, 1'b1, "R10 stack empty");

    @(negedge clk);
    call = 0; ret = 0; iret = 0; irq = 0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule